// File: doc/BRIEF.md
# In-System Programming Session Sequencer

This block is the host side of a serial in-system programming link for a small flash target. One `start` pulse drives the target through a whole session. The block raises the target reset, supplies the target clock when no crystal is fitted, and waits out the power-up time. It then sends the enable instruction and retries it if the target does not acknowledge. Once enabled, it erases the whole array, waits the erase time, and programs the bytes it receives on a ready/valid stream. The addresses for those bytes start at zero and count upward.

After every byte the block lets the target's self-timed write finish. In timed mode it waits a fixed delay. In polling mode it reads the address repeatedly until the top bit of the returned byte matches the byte that was written. It then reads the address once more and compares the result with the intended byte. A mismatch sets a sticky error flag and records the failing address, and the session carries on with the remaining bytes.

At the end of the session the target clock enable drops first, then the reset drops, and `done` goes high. The serial clock comes from a counter and is never faster than one sixteenth of the system clock.

Top module: `isp_seq_master`

## Requirements
- R1: After reset, `tgt_rst`, `tgt_clk_en`, `sck`, `done` and `wr_ready` are all low. A `start` pulse raises `tgt_rst`, and raises `tgt_clk_en` only if `xtal_fitted` is low. `tgt_clk_en` is never high while `tgt_rst` is low.
- R2: The first rising edge of `sck` comes no earlier than PWRUP_CYC clock cycles after `tgt_rst` rises. `sck` is low whenever `tgt_rst` is low.
- R3: The first frame of a session is the enable instruction, bytes AC 53 00 00. The enable is accepted when the fourth byte received equals 69 hex. Otherwise the enable is resent, up to EN_TRIES attempts in total. After the last failed attempt `en_err` goes high, no erase is sent, and the session goes straight to power-down.
- R4: After an accepted enable, the erase instruction AC 80 00 00 is sent, followed by a wait of ERASE_CYC cycles. No write instruction is sent before the erase.
- R5: Each frame is 32 bits, sent MSB first on `mosi`. `mosi` changes only while `sck` is low, and `miso` is sampled at each rising edge of `sck`. The high and low halves of `sck` each last DIV/2 system clock cycles, where DIV is clamped to at least 16.
- R6: `wr_ready` is high only while the block waits for the next byte. Each accepted byte is written with the frame 40, address high byte, address low byte, data. Addresses run from 0 upward, and the byte that arrives with `wr_last` high ends the stream.
- R7: With `poll_mode` low at `start`, no frame begins until WRITE_CYC cycles after a write frame has ended. After that wait, exactly one read frame (20, address, 00) is sent per byte.
- R8: With `poll_mode` high at `start`, read frames for the address just written are repeated until bit 7 of the returned byte equals bit 7 of the written byte, up to POLL_MAX reads. One further verify read follows.
- R9: A verify read whose returned byte differs from the written byte sets `verr`. `verr` stays high until the next accepted `start`. `fail_addr` holds the first failing address, and all later bytes are still written and checked.
- R10: At the end of a session `tgt_clk_en` goes low, and `tgt_rst` goes low one cycle later together with `done` rising. `done` stays high until the next `start`.
- R11: A `start` pulse while a session is running is ignored. No second reset rise and no second enable occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a session when idle or done |
| xtal_fitted | input | 1 | High if the target has its own crystal |
| poll_mode | input | 1 | Selects data polling instead of a timed write wait |
| wr_valid | input | 1 | Byte stream valid |
| wr_ready | output | 1 | Byte stream ready |
| wr_data | input | 8 | Byte to program |
| wr_last | input | 1 | Marks the final byte |
| tgt_rst | output | 1 | Target reset, high during the session |
| tgt_clk_en | output | 1 | Enables the clock supplied to the target |
| sck | output | 1 | Serial shift clock |
| mosi | output | 1 | Serial data to target |
| miso | input | 1 | Serial data from target |
| done | output | 1 | Session finished |
| en_err | output | 1 | Enable never acknowledged |
| verr | output | 1 | Sticky verify mismatch flag |
| fail_addr | output | ADDR_W | First address that failed verification |

## Verification
The hardest situations to reach are the ones the target creates. These are an enable that is rejected several times, a write that is still busy across several polls, and a stored byte that differs from the byte sent. None of them can be forced from the sequencer's own inputs. The bench therefore contains a behavioural target that decodes every frame. It can be told to reject a set number of enables, to return the complemented top bit for a set number of reads after a write, and to corrupt one address as it stores it. Three sessions combine these settings: retry followed by success with timed writes and a stray `start`; polling with a corrupted byte; and retries that run out.

// File: rtl/isp_seq_master.sv
module isp_seq_master #(
  parameter int ADDR_W    = 13,
  parameter int DIV       = 16,
  parameter int PWRUP_CYC = 500000,
  parameter int ERASE_CYC = 25000,
  parameter int WRITE_CYC = 25000,
  parameter int EN_TRIES  = 4,
  parameter int POLL_MAX  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              xtal_fitted,
  input  logic              poll_mode,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  input  logic              wr_last,
  output logic              tgt_rst,
  output logic              tgt_clk_en,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              done,
  output logic              en_err,
  output logic              verr,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int HALF   = (DIV < 16) ? 8 : DIV / 2;
  localparam int HW     = $clog2(HALF);
  localparam int WMAX_A = (PWRUP_CYC > ERASE_CYC) ? PWRUP_CYC : ERASE_CYC;
  localparam int WMAX   = (WMAX_A > WRITE_CYC) ? WMAX_A : WRITE_CYC;
  localparam int WW     = $clog2(WMAX + 1);
  localparam int TW     = $clog2(EN_TRIES + 1);
  localparam int PW     = $clog2(POLL_MAX + 1);

  localparam logic [7:0] OP_PROG = 8'hAC;
  localparam logic [7:0] SUB_EN  = 8'h53;
  localparam logic [7:0] SUB_ER  = 8'h80;
  localparam logic [7:0] OP_WR   = 8'h40;
  localparam logic [7:0] OP_RD   = 8'h20;
  localparam logic [7:0] EN_ACK  = 8'h69;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PWR, ST_EN, ST_ER, ST_ERW, ST_FETCH, ST_WR,
    ST_WW, ST_POLL, ST_VER, ST_OFFC, ST_OFFR, ST_DONE
  } st_t;

  st_t               st;
  logic              go, xbusy, xdone;
  logic [31:0]       frame, sr;
  logic [7:0]        rx;
  logic [HW-1:0]     hcnt;
  logic [4:0]        bitn;
  logic [WW-1:0]     wcnt, wlim;
  logic [TW-1:0]     tries;
  logic [PW-1:0]     polls;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        data;
  logic              last, pmode;
  logic [15:0]       a16;
  logic              wend;

  assign a16      = 16'(addr);
  assign mosi     = xbusy & sr[31];
  assign wr_ready = (st == ST_FETCH);
  assign wend     = (wcnt == wlim);

  always_comb begin
    case (st)
      ST_PWR:  wlim = WW'(PWRUP_CYC - 1);
      ST_ERW:  wlim = WW'(ERASE_CYC - 1);
      default: wlim = WW'(WRITE_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr    <= '0;
      rx    <= '0;
      sck   <= 1'b0;
      xbusy <= 1'b0;
      xdone <= 1'b0;
      hcnt  <= '0;
      bitn  <= '0;
    end else begin
      xdone <= 1'b0;
      if (go) begin
        sr    <= frame;
        xbusy <= 1'b1;
        hcnt  <= '0;
        bitn  <= '0;
      end else if (xbusy) begin
        if (hcnt == HW'(HALF - 1)) begin
          hcnt <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], miso};
          end else begin
            sck  <= 1'b0;
            sr   <= {sr[30:0], 1'b0};
            bitn <= bitn + 5'd1;
            if (bitn == 5'd31) begin
              xbusy <= 1'b0;
              xdone <= 1'b1;
            end
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      tgt_rst    <= 1'b0;
      tgt_clk_en <= 1'b0;
      done       <= 1'b0;
      en_err     <= 1'b0;
      verr       <= 1'b0;
      fail_addr  <= '0;
      addr       <= '0;
      data       <= '0;
      last       <= 1'b0;
      pmode      <= 1'b0;
      wcnt       <= '0;
      tries      <= '0;
      polls      <= '0;
      go         <= 1'b0;
      frame      <= '0;
    end else begin
      go <= 1'b0;
      case (st)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            tgt_rst    <= 1'b1;
            tgt_clk_en <= !xtal_fitted;
            pmode      <= poll_mode;
            done       <= 1'b0;
            en_err     <= 1'b0;
            verr       <= 1'b0;
            fail_addr  <= '0;
            addr       <= '0;
            wcnt       <= '0;
            tries      <= '0;
            st         <= ST_PWR;
          end
        end
        ST_PWR: begin
          if (wend) begin
            wcnt  <= '0;
            tries <= TW'(1);
            go    <= 1'b1;
            frame <= {OP_PROG, SUB_EN, 16'h0000};
            st    <= ST_EN;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_EN: begin
          if (xdone) begin
            if (rx == EN_ACK) begin
              go    <= 1'b1;
              frame <= {OP_PROG, SUB_ER, 16'h0000};
              st    <= ST_ER;
            end else if (tries == TW'(EN_TRIES)) begin
              en_err <= 1'b1;
              st     <= ST_OFFC;
            end else begin
              tries <= tries + 1'b1;
              go    <= 1'b1;
            end
          end
        end
        ST_ER: begin
          if (xdone) st <= ST_ERW;
        end
        ST_ERW: begin
          if (wend) begin
            wcnt <= '0;
            st   <= ST_FETCH;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_FETCH: begin
          if (wr_valid) begin
            data  <= wr_data;
            last  <= wr_last;
            go    <= 1'b1;
            frame <= {OP_WR, a16, wr_data};
            st    <= ST_WR;
          end
        end
        ST_WR: begin
          if (xdone) begin
            if (pmode) begin
              go    <= 1'b1;
              frame <= {OP_RD, a16, 8'h00};
              polls <= PW'(1);
              st    <= ST_POLL;
            end else begin
              st <= ST_WW;
            end
          end
        end
        ST_WW: begin
          if (wend) begin
            wcnt  <= '0;
            go    <= 1'b1;
            frame <= {OP_RD, a16, 8'h00};
            st    <= ST_VER;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_POLL: begin
          if (xdone) begin
            go <= 1'b1;
            if (rx[7] == data[7] || polls == PW'(POLL_MAX)) st <= ST_VER;
            else polls <= polls + 1'b1;
          end
        end
        ST_VER: begin
          if (xdone) begin
            if (rx != data) begin
              verr <= 1'b1;
              if (!verr) fail_addr <= addr;
            end
            if (last) begin
              st <= ST_OFFC;
            end else begin
              addr <= addr + 1'b1;
              st   <= ST_FETCH;
            end
          end
        end
        ST_OFFC: begin
          tgt_clk_en <= 1'b0;
          st         <= ST_OFFR;
        end
        ST_OFFR: begin
          tgt_rst <= 1'b0;
          done    <= 1'b1;
          st      <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/isp_seq_master_chk.sv
module isp_seq_master_chk #(
  parameter int DIV = 16
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic sck,
  input logic tgt_rst,
  input logic tgt_clk_en,
  input logic wr_ready,
  input logic done,
  input logic verr
);
  localparam int HALF = (DIV < 16) ? 8 : DIV / 2;

  logic        sck_q;
  logic [15:0] hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      hold  <= '0;
    end else begin
      sck_q <= sck;
      if (sck != sck_q) hold <= '0;
      else if (hold != 16'hFFFF) hold <= hold + 16'd1;
    end
  end

  // R5
  sck_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != sck_q) |-> (hold >= 16'(HALF - 1)));

  // R1
  clk_en_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_clk_en |-> tgt_rst);

  // R2
  sck_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> tgt_rst);

  // R10
  off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_rst) |-> (!tgt_clk_en && !$past(tgt_clk_en)));

  // R9
  verr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verr && !start) |=> verr);

  // R6
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (tgt_rst && !done && !sck));
endmodule

bind isp_seq_master isp_seq_master_chk #(.DIV(DIV)) u_chk (.*);

// File: tb/test_isp_seq_master.sv
`timescale 1ns/1ps
module test_isp_seq_master;
  localparam int AW = 8, DIV = 16, PWR = 200, ERA = 100, WRT = 60, TRIES = 3, PMAX = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, xtal_fitted = 1'b0, poll_mode = 1'b0;
  logic wr_valid = 1'b0, wr_last = 1'b0, miso = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_ready, tgt_rst, tgt_clk_en, sck, mosi, done, en_err, verr;
  logic [AW-1:0] fail_addr;

  always #10 clk = ~clk;

  isp_seq_master #(.ADDR_W(AW), .DIV(DIV), .PWRUP_CYC(PWR), .ERASE_CYC(ERA),
    .WRITE_CYC(WRT), .EN_TRIES(TRIES), .POLL_MAX(PMAX)) i_isp_seq_master (
    .clk(clk), .rst_n(rst_n), .start(start), .xtal_fitted(xtal_fitted),
    .poll_mode(poll_mode), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_last(wr_last), .tgt_rst(tgt_rst),
    .tgt_clk_en(tgt_clk_en), .sck(sck), .mosi(mosi), .miso(miso),
    .done(done), .en_err(en_err), .verr(verr), .fail_addr(fail_addr));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic [7:0]  mem [256];
  logic [15:0] q [$];
  logic [7:0]  exp_d [16];
  int  bitc = 0, en_fail_left = 0, busy_reads = 0, busy_left = 0, corrupt = -1;
  int  n_en = 0, n_er = 0, n_wr = 0, n_rd = 0, n_rst = 0;
  bit  enabled = 0, erased = 0, first_frame = 0, after_write = 0, timed = 0, sess = 0;
  logic [31:0] cmd = '0;
  logic [7:0]  resp = '0, last_wa = '0;
  time t_rst = 0, t_rise0 = 0, t_wr = 0;

  always @(posedge tgt_rst) begin
    t_rst = $time;
    first_frame = 1;
    n_rst++;
  end

  always @(negedge tgt_rst) if (sess) chk(!tgt_clk_en, "R10 clk_en low at reset release", 32'(tgt_clk_en), 0);

  always @(negedge sck) if (bitc >= 24) miso = resp[31 - bitc];

  // monitor: target model, pops the scoreboard on each write frame
  always @(posedge sck) begin
    cmd = {cmd[30:0], mosi};
    if (bitc == 0) begin
      t_rise0 = $time;
      if (first_frame)
        chk(($time - t_rst) >= PWR * 20, "R2 power-up wait", 32'($time - t_rst), 32'(PWR * 20));
      if (after_write && timed)
        chk(($time - t_wr) >= WRT * 20, "R7 write wait", 32'($time - t_wr), 32'(WRT * 20));
      after_write = 0;
    end
    if (bitc == 1) chk(($time - t_rise0) == DIV * 20, "R5 sck period", 32'($time - t_rise0), 32'(DIV * 20));
    bitc++;
    if (bitc == 24) begin
      if (cmd[23:8] == 16'hAC53) resp = (en_fail_left > 0) ? 8'h00 : 8'h69;
      else if (cmd[23:16] == 8'h20) begin
        if (busy_left > 0 && cmd[7:0] == last_wa) begin
          resp = {~mem[cmd[7:0]][7], mem[cmd[7:0]][6:0]};
          busy_left--;
        end else resp = mem[cmd[7:0]];
      end else resp = 8'h00;
    end
    if (bitc == 32) begin
      bitc = 0;
      if (first_frame) chk(cmd[31:16] == 16'hAC53, "R3 first frame is enable", cmd, 32'hAC530000);
      first_frame = 0;
      if (cmd[31:16] == 16'hAC53) begin
        n_en++;
        if (en_fail_left > 0) en_fail_left--;
        else enabled = 1;
      end else if (cmd[31:16] == 16'hAC80) begin
        n_er++;
        chk(enabled, "R4 erase after enable", 32'(enabled), 1);
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        erased = 1;
      end else if (cmd[31:24] == 8'h40) begin
        n_wr++;
        chk(erased, "R4 erase before write", 32'(erased), 1);
        mem[cmd[15:8]] = cmd[7:0] ^ ((int'(cmd[15:8]) == corrupt) ? 8'h01 : 8'h00);
        busy_left = busy_reads;
        last_wa = cmd[15:8];
        t_wr = $time;
        after_write = 1;
        if (q.size() == 0) chk(0, "R6 unexpected write", cmd, 0);
        else begin
          logic [15:0] e;
          e = q.pop_front();
          chk(cmd[23:0] == {8'h00, e}, "R6 write frame", {8'h00, cmd[23:0]}, {16'h0000, e});
        end
      end else if (cmd[31:24] == 8'h20) n_rd++;
    end
  end

  // driver: pushes expected writes and feeds the byte stream
  task automatic run_session(input bit xtal, input bit poll, input int nb, input int enf,
                             input int busyr, input int corr, input bit mid_start, input bit exp_err);
    en_fail_left = enf; busy_reads = busyr; busy_left = 0; corrupt = corr;
    enabled = 0; erased = 0; n_en = 0; n_er = 0; n_wr = 0; n_rd = 0; n_rst = 0;
    timed = !poll; after_write = 0; sess = 1;
    xtal_fitted = xtal; poll_mode = poll;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (2) @(negedge clk);
    chk(tgt_rst == 1'b1, "R1 reset raised", 32'(tgt_rst), 1);
    chk(tgt_clk_en == !xtal, "R1 clock enable", 32'(tgt_clk_en), 32'(!xtal));
    chk(done == 1'b0, "R10 done cleared", 32'(done), 0);
    if (!exp_err) begin
      for (int i = 0; i < nb; i++) begin
        exp_d[i] = 8'(8'h3A + i * 8'd77);
        q.push_back({8'(i), exp_d[i]});
        wr_valid = 1; wr_data = exp_d[i]; wr_last = (i == nb - 1);
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 0;
        if (mid_start && i == 1) begin
          start = 1;
          @(negedge clk) start = 0;
        end
      end
    end
    while (!done) @(negedge clk);
    chk(en_err == exp_err, "R3 enable error flag", 32'(en_err), 32'(exp_err));
    chk(n_en == (exp_err ? TRIES : enf + 1), "R3 enable attempts", 32'(n_en), 32'(exp_err ? TRIES : enf + 1));
    chk(n_er == (exp_err ? 0 : 1), "R4 erase count", 32'(n_er), 32'(exp_err ? 0 : 1));
    chk(q.size() == 0 && n_wr == nb, "R6 all bytes written", 32'(n_wr), 32'(nb));
    chk(n_rd == nb * (poll ? busyr + 2 : 1), poll ? "R8 read count" : "R7 read count",
        32'(n_rd), 32'(nb * (poll ? busyr + 2 : 1)));
    chk(verr == (corr >= 0), "R9 verify flag", 32'(verr), 32'(corr >= 0));
    if (corr >= 0) chk(fail_addr == AW'(corr), "R9 failing address", 32'(fail_addr), 32'(corr));
    for (int i = 0; i < nb; i++)
      chk(mem[i] == (exp_d[i] ^ ((i == corr) ? 8'h01 : 8'h00)), "R6 stored byte",
          32'(mem[i]), 32'(exp_d[i] ^ ((i == corr) ? 8'h01 : 8'h00)));
    chk(n_rst == 1, "R11 stray start ignored", 32'(n_rst), 1);
    chk(!tgt_rst && !tgt_clk_en, "R10 target released", {30'd0, tgt_rst, tgt_clk_en}, 0);
    repeat (20) @(negedge clk);
    chk(done && !wr_ready && !sck, "R10 done held", {29'd0, done, wr_ready, sck}, 32'd4);
    sess = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk({tgt_rst, tgt_clk_en, sck, done, wr_ready} == 5'b0, "R1 reset state",
        {27'd0, tgt_rst, tgt_clk_en, sck, done, wr_ready}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    run_session(1'b0, 1'b0, 5, 2, 0, -1, 1'b1, 1'b0);
    run_session(1'b1, 1'b1, 4, 0, 3, 2, 1'b0, 1'b0);
    run_session(1'b0, 1'b0, 0, 99, 0, -1, 1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R10: actual timeout expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule